// File: doc/BRIEF.md
# Multi-function pin controller

This block owns one multi-purpose device pad and the handful of byte-wide configuration and status registers that decide what the pad does. Software writes and reads the registers through a plain byte port (address, write data, write strobe, read data). A two-bit role field picks whether the pad feeds a fan tachometer counter, carries an over-temperature request, carries a bus alert request, or acts as a general-purpose I/O.

The tachometer counter, the temperature logic and the serial bus slave live elsewhere. Here they show up only as signals: a synchronized tachometer level going out, and two drive requests coming in. In general-purpose mode the block applies a direction bit and a polarity bit to a stored output value. When the pad is an input, it passes the level through a two-flop synchronizer and shows it in the status register.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset, a read of 0x40 returns 0x01, and reads of 0x73, 0x78, 0x7C, 0x42 and 0x7D return 0x00. The pad role is therefore tachometer.
- R2: A write to any of 0x40, 0x73, 0x78, 0x7C, 0x42 or 0x7D stores the full byte, and a later read returns it. The one exception is bit 5 of 0x42, as R7 describes.
- R3: A read from any other address returns 0x00. A write to any other address changes no stored register.
- R4: While bits 1:0 of 0x7D equal 00 (tachometer), pad_oe is 0, pad_o is 0, and tach_o equals the synchronized pad level.
- R5: While bits 1:0 of 0x7D equal 01 (thermal), pad_oe follows therm_req_i and pad_o is 0, so the pad is pulled low only while a request is active.
- R6: While bits 1:0 of 0x7D equal 10 (alert), pad_oe follows alert_req_i and pad_o is 0. therm_req_i has no effect in this role.
- R7: While bits 1:0 of 0x7D equal 11 and bit 2 of 0x7C is 0 (input), pad_oe is 0. A read of 0x42 then returns the synchronized pad level in bit 5.
- R8: While bits 1:0 of 0x7D equal 11 and bit 2 of 0x7C is 1 (output), pad_oe is 1. pad_o equals bit 5 of 0x42 when bit 3 of 0x7C is 1 (active high), and its inverse when that bit is 0 (active low).
- R9: pad_sync_o shows the level that pad_i held just before the second-to-last rising clock edge, so a change on pad_i appears after exactly two edges.
- R10: tach_o is 0 whenever the role is not tachometer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_i | input | 1 | Level sampled from the pad |
| pad_o | output | 1 | Value driven onto the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_sync_o | output | 1 | Synchronized pad level |
| tach_o | output | 1 | Synchronized level for the tachometer counter |
| therm_req_i | input | 1 | Over-temperature drive request |
| alert_req_i | input | 1 | Bus alert drive request |

## Verification
Every cycle the assertions check the pad routing for each role (enable and driven value against the stored role, direction, polarity and value bits), the gating of tach_o, the reset contents, and that writes to unmapped addresses leave all registers unchanged. Some behaviour only the bench scenarios can show, because it spans several cycles or passes through the read port. That covers the two-edge latency of the synchronizer, the read-back of written bytes, the substitution of the pad level into bit 5 of the status register, and the zero returned by reads of unmapped addresses.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int BYTE_W = 8;

    // Register addresses decoded by software
    localparam logic [7:0] ADR_CFG1  = 8'h40;
    localparam logic [7:0] ADR_STAT2 = 8'h42;
    localparam logic [7:0] ADR_CFG2  = 8'h73;
    localparam logic [7:0] ADR_CFG3  = 8'h78;
    localparam logic [7:0] ADR_CFG4  = 8'h7C;
    localparam logic [7:0] ADR_CFG5  = 8'h7D;

    localparam logic [7:0] RST_CFG1 = 8'h01;

    // Field positions
    localparam int DIR_BIT = 2;
    localparam int POL_BIT = 3;
    localparam int VAL_BIT = 5;

    typedef enum logic [1:0] {
        ROLE_TACH  = 2'b00,
        ROLE_THERM = 2'b01,
        ROLE_ALERT = 2'b10,
        ROLE_GPIO  = 2'b11
    } pin_role_e;

    typedef struct packed {
        logic [BYTE_W-1:0] cfg1;
        logic [BYTE_W-1:0] cfg2;
        logic [BYTE_W-1:0] cfg3;
        logic [BYTE_W-1:0] cfg4;
        logic [BYTE_W-1:0] cfg5;
        logic [BYTE_W-1:0] stat2;
    } pin_regs_t;

    localparam pin_regs_t REGS_RESET = '{
        cfg1:  RST_CFG1,
        cfg2:  '0,
        cfg3:  '0,
        cfg4:  '0,
        cfg5:  '0,
        stat2: '0
    };

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[SW-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[SW-1];
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              pad_lvl,
    output pin_regs_t         regs,
    output logic [BYTE_W-1:0] rdata
);
    pin_regs_t regs_d, regs_q;
    logic      gpio_in;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if      (addr == AW'(ADR_CFG1))  regs_d.cfg1  = wdata;
            else if (addr == AW'(ADR_CFG2))  regs_d.cfg2  = wdata;
            else if (addr == AW'(ADR_CFG3))  regs_d.cfg3  = wdata;
            else if (addr == AW'(ADR_CFG4))  regs_d.cfg4  = wdata;
            else if (addr == AW'(ADR_CFG5))  regs_d.cfg5  = wdata;
            else if (addr == AW'(ADR_STAT2)) regs_d.stat2 = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    assign gpio_in = (pin_role_e'(regs_q.cfg5[1:0]) == ROLE_GPIO) && !regs_q.cfg4[DIR_BIT];

    always_comb begin
        rdata = '0;
        if      (addr == AW'(ADR_CFG1))  rdata = regs_q.cfg1;
        else if (addr == AW'(ADR_CFG2))  rdata = regs_q.cfg2;
        else if (addr == AW'(ADR_CFG3))  rdata = regs_q.cfg3;
        else if (addr == AW'(ADR_CFG4))  rdata = regs_q.cfg4;
        else if (addr == AW'(ADR_CFG5))  rdata = regs_q.cfg5;
        else if (addr == AW'(ADR_STAT2)) begin
            rdata = regs_q.stat2;
            if (gpio_in) rdata[VAL_BIT] = pad_lvl;
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
    import pinmux_pkg::*;
(
    input  pin_role_e role,
    input  logic      dir_out,
    input  logic      pol_high,
    input  logic      out_val,
    input  logic      therm_req,
    input  logic      alert_req,
    input  logic      pad_lvl,
    output logic      pad_o,
    output logic      pad_oe,
    output logic      tach_o
);
    always_comb begin
        pad_o  = 1'b0;
        pad_oe = 1'b0;
        tach_o = 1'b0;
        unique case (role)
            ROLE_TACH:  tach_o = pad_lvl;
            ROLE_THERM: pad_oe = therm_req;
            ROLE_ALERT: pad_oe = alert_req;
            ROLE_GPIO: begin
                pad_oe = dir_out;
                if (dir_out) pad_o = pol_high ? out_val : ~out_val;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              pad_i,
    output logic              pad_o,
    output logic              pad_oe,
    output logic              pad_sync_o,
    output logic              tach_o,
    input  logic              therm_req_i,
    input  logic              alert_req_i
);
    pin_regs_t regs_q;
    pin_role_e role;
    logic      pad_lvl;

    pinmux_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_i),
        .dout (pad_lvl)
    );

    pinmux_regs #(.AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pad_lvl(pad_lvl),
        .regs   (regs_q),
        .rdata  (reg_rdata)
    );

    assign role = pin_role_e'(regs_q.cfg5[1:0]);

    pinmux_route u_route (
        .role     (role),
        .dir_out  (regs_q.cfg4[DIR_BIT]),
        .pol_high (regs_q.cfg4[POL_BIT]),
        .out_val  (regs_q.stat2[VAL_BIT]),
        .therm_req(therm_req_i),
        .alert_req(alert_req_i),
        .pad_lvl  (pad_lvl),
        .pad_o    (pad_o),
        .pad_oe   (pad_oe),
        .tach_o   (tach_o)
    );

    assign pad_sync_o = pad_lvl;
endmodule

// File: rtl/pinmux_ctrl_chk.sv
module pinmux_ctrl_chk
    import pinmux_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input pin_regs_t     regs_q,
    input logic          therm_req_i,
    input logic          alert_req_i,
    input logic          pad_o,
    input logic          pad_oe,
    input logic          tach_o,
    input logic          pad_sync_o
);
    logic [1:0] fn;
    logic       mapped;

    assign fn = regs_q.cfg5[1:0];
    assign mapped = (reg_addr == AW'(ADR_CFG1)) || (reg_addr == AW'(ADR_CFG2)) ||
                    (reg_addr == AW'(ADR_CFG3)) || (reg_addr == AW'(ADR_CFG4)) ||
                    (reg_addr == AW'(ADR_CFG5)) || (reg_addr == AW'(ADR_STAT2));

    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q.cfg1 == 8'h01 && regs_q.cfg2 == 8'h00 && regs_q.cfg3 == 8'h00 &&
                          regs_q.cfg4 == 8'h00 && regs_q.cfg5 == 8'h00 && regs_q.stat2 == 8'h00));

    assert_unmapped_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !mapped) |=> $stable(regs_q));

    assert_tach_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b00) |-> (!pad_oe && !pad_o && tach_o == pad_sync_o));

    assert_therm_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b01) |-> (pad_oe == therm_req_i && !pad_o));

    assert_alert_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b10) |-> (pad_oe == alert_req_i && !pad_o));

    assert_gpio_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b11 && !regs_q.cfg4[2]) |-> !pad_oe);

    assert_gpio_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b11 && regs_q.cfg4[2]) |->
        (pad_oe && pad_o == (regs_q.cfg4[3] ? regs_q.stat2[5] : !regs_q.stat2[5])));

    assert_tach_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fn != 2'b00) |-> !tach_o);
endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .regs_q     (regs_q),
    .therm_req_i(therm_req_i),
    .alert_req_i(alert_req_i),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe),
    .tach_o     (tach_o),
    .pad_sync_o (pad_sync_o)
);

// File: tb/pinmux_ctrl_test.sv
module pinmux_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pad_i = 1'b0;
    logic       pad_o, pad_oe, pad_sync_o, tach_o;
    logic       therm_req_i = 1'b0;
    logic       alert_req_i = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    string phase = "R1";

    // Reference model: index 0..5 = 0x40,0x73,0x78,0x7C,0x7D,0x42
    int m_reg[6] = '{1, 0, 0, 0, 0, 0};
    int s1 = 0;
    int s2 = 0;

    always #2.5 clk = ~clk;

    pinmux_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pad_i      (pad_i),
        .pad_o      (pad_o),
        .pad_oe     (pad_oe),
        .pad_sync_o (pad_sync_o),
        .tach_o     (tach_o),
        .therm_req_i(therm_req_i),
        .alert_req_i(alert_req_i)
    );

    function automatic int slot(input logic [7:0] a);
        case (a)
            8'h40: return 0;
            8'h73: return 1;
            8'h78: return 2;
            8'h7C: return 3;
            8'h7D: return 4;
            8'h42: return 5;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = '{1, 0, 0, 0, 0, 0};
            s1 = 0;
            s2 = 0;
        end else begin
            if (reg_we && slot(reg_addr) >= 0) m_reg[slot(reg_addr)] = int'(reg_wdata);
            s2 = s1;
            s1 = int'(pad_i);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int fn, dir, pol, val, erd, eoe, eo, idx;
        string rtag;
        fn  = m_reg[4] & 3;
        dir = (m_reg[3] >> 2) & 1;
        pol = (m_reg[3] >> 3) & 1;
        val = (m_reg[5] >> 5) & 1;
        idx = slot(reg_addr);
        erd = (idx < 0) ? 0 : m_reg[idx];
        rtag = phase;
        if (reg_addr == 8'h42 && fn == 3 && dir == 0) begin
            erd = (erd & ~32) | (s2 << 5);
            rtag = "R7";
        end
        chk(rtag, "reg_rdata", int'(reg_rdata), erd);
        eoe = 0; eo = 0;
        case (fn)
            1: eoe = int'(therm_req_i);
            2: eoe = int'(alert_req_i);
            3: begin eoe = dir; if (dir == 1) eo = pol ? val : 1 - val; end
            default: ;
        endcase
        rtag = (fn == 0) ? "R4" : (fn == 1) ? "R5" : (fn == 2) ? "R6" : (dir == 1) ? "R8" : "R7";
        chk(rtag, "pad_oe", int'(pad_oe), eoe);
        chk(rtag, "pad_o", int'(pad_o), eo);
        chk((fn == 0) ? "R4" : "R10", "tach_o", int'(tach_o), (fn == 0) ? s2 : 0);
        chk("R9", "pad_sync_o", int'(pad_sync_o), s2);
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        reg_addr = a;
        cyc();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        phase = "R1";
        rd(8'h40); rd(8'h73); rd(8'h78); rd(8'h7C); rd(8'h7D); rd(8'h42);

        // R2: byte write and read-back
        phase = "R2";
        wr(8'h40, 8'hA5); rd(8'h40);
        wr(8'h73, 8'h3C); rd(8'h73);
        wr(8'h78, 8'h5A); rd(8'h78);
        wr(8'h7C, 8'hF0); rd(8'h7C);
        wr(8'h42, 8'hDF); rd(8'h42);
        wr(8'h7D, 8'hFC); rd(8'h7D);

        // R3: unmapped addresses
        phase = "R3";
        wr(8'h41, 8'hFF); rd(8'h41);
        wr(8'h7E, 8'hFF); rd(8'h7E);
        wr(8'h00, 8'hFF); rd(8'h00);
        wr(8'h7D, 8'hAA); rd(8'hFF);
        rd(8'h40); rd(8'h73); rd(8'h78); rd(8'h7C); rd(8'h7D); rd(8'h42);

        // R4, R9: tachometer role, pad toggling
        phase = "R4";
        wr(8'h7D, 8'h00); wr(8'h7C, 8'h0C);
        for (int i = 0; i < 12; i++) begin
            pad_i = ((i % 3) == 0) ? 1'b1 : ((i % 5) == 1);
            therm_req_i = i[0];
            cyc();
        end

        // R5: thermal role
        phase = "R5";
        wr(8'h7D, 8'h01);
        for (int i = 0; i < 8; i++) begin
            therm_req_i = i[1]; alert_req_i = i[0]; pad_i = i[2];
            cyc();
        end

        // R6: alert role, thermal request ignored
        phase = "R6";
        wr(8'h7D, 8'h02);
        for (int i = 0; i < 8; i++) begin
            therm_req_i = i[0]; alert_req_i = i[1]; pad_i = i[0];
            cyc();
        end
        therm_req_i = 1'b0; alert_req_i = 1'b0;

        // R7: GPIO input, level reflected into status bit 5
        phase = "R7";
        wr(8'h42, 8'h00); wr(8'h7C, 8'h08); wr(8'h7D, 8'h03);
        reg_addr = 8'h42;
        for (int i = 0; i < 10; i++) begin
            pad_i = (i >= 2 && i < 6);
            cyc();
        end
        wr(8'h42, 8'h20); rd(8'h42);

        // R8: GPIO output, both polarities and values
        phase = "R8";
        pad_i = 1'b0;
        wr(8'h7C, 8'h0C); rd(8'h42);
        wr(8'h42, 8'h00); rd(8'h7C);
        wr(8'h7C, 8'h04); rd(8'h42);
        wr(8'h42, 8'h20); rd(8'h42);
        wr(8'h7D, 8'hFF); rd(8'h7D);
        wr(8'h7C, 8'h00); rd(8'h42);

        // R10: leave GPIO, tach output returns to gating by role
        phase = "R10";
        wr(8'h7D, 8'h02); pad_i = 1'b1;
        repeat (4) cyc();
        wr(8'h7D, 8'h00);
        repeat (4) cyc();

        finish_run();
    end
endmodule